// File: doc/BRIEF.md
# Shared Interrupt Distributor

This block takes a set of common interrupt sources, shared by all cores of a cluster, and steers each of them onto the local interrupt lines of one or more cores. Each source has its own configuration. A destination mask names the cores that may receive it. A scheme selects either fixed delivery to every core in that mask or rotation among those cores. A trigger bit selects level or edge behaviour, and a mask bit blocks the source. A single global enable holds every output low until the cluster software turns the distributor on.

Configuration arrives over a command port with a valid/ready handshake. Each command carries an opcode, a source number and a 32-bit data word. The port never applies back-pressure. `cmd_ready` is high at all times. A command is accepted on every rising clock edge where `cmd_valid` is high, and its effect is visible from the next cycle. The source inputs are assumed to be synchronous to `clk`.

The output bus holds one line per source per core. Core `c` sees source `i` on bit `c*NUM_IRQ + i`, so each core receives all common sources on a contiguous group of its local inputs.

Top module: `idu_top`

## Requirements
- R1: After reset, all outputs are low, every source is masked, every destination mask is empty, every scheme is round-robin and the distributor is disabled.
- R2: Opcode 0 (enable) turns the distributor on. Until that command has been accepted, every output stays low whatever the inputs and the other configuration.
- R3: Opcode 1 (set destination) stores data bits [NUM_CORE-1:0] as the core mask of the addressed source, with bit c naming core c. Higher data bits are ignored.
- R4: Opcode 2 (set mode) takes data bits [1:0] as the scheme, where 0 is round-robin and any other value is fixed destination. Data bit 4 set means level trigger and clear means edge trigger. All other data bits are ignored.
- R5: Opcode 3 (set mask) blocks the addressed source when data bit 0 is 1 and unblocks it when that bit is 0. Other data bits are ignored. A blocked source drives no output.
- R6: In fixed-destination level mode, every core in the mask sees the source line high in exactly the cycles where the input is high, with no added latency.
- R7: In round-robin mode, each rising input picks the next core in the mask, scanning upward from the core served last and wrapping around. The first pick after reset starts the scan at core 0. While the input stays high in level mode, the line of the most recently served core stays high, and no other core of that source is driven.
- R8: A rising input on a source whose mask is empty, or that is blocked or disabled, delivers nothing and leaves the round-robin position unchanged.
- R9: In edge mode, a rising input produces a one-cycle pulse: to every masked core under fixed destination, or to the picked core under round-robin.
- R10: Source i for core c appears on `irq_out` bit c*NUM_IRQ + i.
- R11: `cmd_ready` is always high. A command presented in a cycle does not affect that cycle's outputs; it takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always high) |
| cmd_op | input | 2 | Opcode: 0 enable, 1 destination, 2 mode, 3 mask |
| cmd_irq | input | $clog2(NUM_IRQ) | Addressed common source |
| cmd_data | input | 32 | Command data word |
| irq_in | input | NUM_IRQ | Common interrupt sources |
| irq_out | output | NUM_CORE*NUM_IRQ | Per-core lines, core c at bits [c*NUM_IRQ +: NUM_IRQ] |

## Verification
A configuration command and a rising source input can land in the same cycle. The bench provokes this by presenting an unmask command for a fixed-destination level source in the very cycle its input rises. That cycle must still show the source as blocked, and the next cycle must show the line on its destination core while the input stays high. The round-robin position is also judged across blocked and empty-mask rises, where the next delivered pick must continue from the last core that was actually served.

// File: rtl/idu_pkg.sv
package idu_pkg;

  localparam int CMD_W       = 32;
  localparam int MODE_LVL_B  = 4;

  typedef enum logic [1:0] {
    OP_ENABLE = 2'd0,
    OP_DEST   = 2'd1,
    OP_MODE   = 2'd2,
    OP_MASK   = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    SCH_ROTATE = 2'd0,
    SCH_FIXED  = 2'd1
  } scheme_e;

endpackage

// File: rtl/idu_cfg.sv
module idu_cfg #(
  parameter int NUM_IRQ  = 8,
  parameter int NUM_CORE = 4,
  localparam int IRQ_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cmd_valid,
  input  logic [1:0]                         cmd_op,
  input  logic [IRQ_W-1:0]                   cmd_irq,
  input  logic [idu_pkg::CMD_W-1:0]          cmd_data,
  output logic                               enabled,
  output logic [NUM_IRQ-1:0][NUM_CORE-1:0]   dest,
  output logic [NUM_IRQ-1:0]                 rr_mode,
  output logic [NUM_IRQ-1:0]                 level,
  output logic [NUM_IRQ-1:0]                 masked
);
  import idu_pkg::*;

  cmd_op_e op;
  assign op = cmd_op_e'(cmd_op);

  logic unused_data_bits;
  assign unused_data_bits = ^cmd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enabled <= 1'b0;
    end else if (cmd_valid && op == OP_ENABLE) begin
      enabled <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_slot
    logic hit;
    assign hit = cmd_valid && (cmd_irq == IRQ_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dest[i]    <= '0;
        rr_mode[i] <= 1'b1;
        level[i]   <= 1'b0;
        masked[i]  <= 1'b1;
      end else if (hit) begin
        case (op)
          OP_DEST: dest[i] <= cmd_data[NUM_CORE-1:0];
          OP_MODE: begin
            rr_mode[i] <= (scheme_e'(cmd_data[1:0]) == SCH_ROTATE);
            level[i]   <= cmd_data[MODE_LVL_B];
          end
          OP_MASK: masked[i] <= cmd_data[0];
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/idu_lane.sv
module idu_lane #(
  parameter int NUM_CORE = 4,
  localparam int IDX_W   = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                src,
  input  logic                gate,
  input  logic [NUM_CORE-1:0] dest,
  input  logic                rr_mode,
  input  logic                level,
  output logic [NUM_CORE-1:0] lines
);

  function automatic logic [IDX_W-1:0] scan_after(input logic [IDX_W-1:0] from,
                                                  input logic [NUM_CORE-1:0] m);
    logic [IDX_W-1:0] r;
    logic             got;
    r   = from;
    got = 1'b0;
    for (int k = 1; k <= NUM_CORE; k++) begin
      int j;
      j = (int'(from) + k) % NUM_CORE;
      if (!got && m[j]) begin
        r   = IDX_W'(j);
        got = 1'b1;
      end
    end
    return r;
  endfunction

  logic             src_q;
  logic [IDX_W-1:0] last_q;
  logic [IDX_W-1:0] pick;
  logic [IDX_W-1:0] cur;
  logic             rise;
  logic             live;
  logic             served;
  logic [NUM_CORE-1:0] rr_lines;
  logic             active;

  assign rise   = src & ~src_q;
  assign live   = gate & (|dest);
  assign pick   = scan_after(last_q, dest);
  assign served = rise & live & rr_mode;
  assign cur    = served ? pick : last_q;

  assign rr_lines = (NUM_CORE'(1) << cur) & dest;
  assign active   = level ? src : rise;
  assign lines    = (gate && active) ? (rr_mode ? rr_lines : dest) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= 1'b0;
      last_q <= IDX_W'(NUM_CORE - 1);
    end else begin
      src_q <= src;
      if (served) last_q <= pick;
    end
  end

endmodule

// File: rtl/idu_top.sv
module idu_top #(
  parameter int NUM_IRQ  = 8,
  parameter int NUM_CORE = 4,
  localparam int IRQ_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int OUT_W   = NUM_IRQ * NUM_CORE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [IRQ_W-1:0] cmd_irq,
  input  logic [31:0]      cmd_data,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic [OUT_W-1:0] irq_out
);

  logic                             enabled;
  logic [NUM_IRQ-1:0][NUM_CORE-1:0] dest;
  logic [NUM_IRQ-1:0]               rr_mode;
  logic [NUM_IRQ-1:0]               level;
  logic [NUM_IRQ-1:0]               masked;

  assign cmd_ready = 1'b1;

  idu_cfg #(.NUM_IRQ(NUM_IRQ), .NUM_CORE(NUM_CORE)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_irq  (cmd_irq),
    .cmd_data (cmd_data),
    .enabled  (enabled),
    .dest     (dest),
    .rr_mode  (rr_mode),
    .level    (level),
    .masked   (masked)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_lane
    logic [NUM_CORE-1:0] lines;

    idu_lane #(.NUM_CORE(NUM_CORE)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (irq_in[i]),
      .gate   (enabled & ~masked[i]),
      .dest   (dest[i]),
      .rr_mode(rr_mode[i]),
      .level  (level[i]),
      .lines  (lines)
    );

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      assign irq_out[c*NUM_IRQ + i] = lines[c];
    end
  end

endmodule

// File: rtl/idu_checker.sv
module idu_checker #(
  parameter int NUM_IRQ  = 8,
  parameter int NUM_CORE = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_IRQ-1:0]          irq_in,
  input logic [NUM_IRQ*NUM_CORE-1:0] irq_out,
  input logic                        enabled,
  input logic [NUM_IRQ-1:0]          masked,
  input logic [NUM_IRQ-1:0]          rr_mode,
  input logic [NUM_IRQ-1:0]          level
);

  logic [NUM_CORE-1:0] per_src [NUM_IRQ];

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++)
      for (int c = 0; c < NUM_CORE; c++)
        per_src[i][c] = irq_out[c*NUM_IRQ + i];
  end

  p_dark_until_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> (irq_out == '0));

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    p_out_needs_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|per_src[i]) |-> irq_in[i]);

    p_blocked_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      masked[i] |-> (per_src[i] == '0));

    p_rotate_single_core_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rr_mode[i] |-> $onehot0(per_src[i]));

    p_edge_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!level[i] && (|per_src[i])) |=> ((per_src[i] == '0) || level[i]));
  end

endmodule

bind idu_top idu_checker #(.NUM_IRQ(NUM_IRQ), .NUM_CORE(NUM_CORE)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .irq_in (irq_in),
  .irq_out(irq_out),
  .enabled(enabled),
  .masked (masked),
  .rr_mode(rr_mode),
  .level  (level)
);

// File: tb/test_idu_top.sv
module test_idu_top;
  localparam int NI = 8;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [1:0]  cmd_op;
  logic [2:0]  cmd_irq;
  logic [31:0] cmd_data;
  logic [NI-1:0]    irq_in;
  logic [NI*NC-1:0] irq_out;

  always #5 clk = ~clk;

  idu_top #(.NUM_IRQ(NI), .NUM_CORE(NC)) i_idu_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_irq(cmd_irq), .cmd_data(cmd_data),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [31:0] line(input int c, input int i);
    return 32'b1 << (c*NI + i);
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input logic [31:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor: compares one expected item per cycle, mid-cycle
  always @(negedge clk) begin : mon
    logic [31:0] e;
    string       t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (irq_out !== e) begin
        fails++;
        $display("FAIL %s: irq_out=%h expected %h", t, irq_out, e);
      end
    end
  end

  task automatic cmd(input logic [1:0] op, input int irq, input logic [31:0] d);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_irq   = 3'(irq);
    cmd_data  = d;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic rr_level_pulse(input int irq, input int core, input string tag);
    irq_in[irq] = 1'b1;
    expect_out(line(core, irq), {tag, " pick"});
    step();
    expect_out(line(core, irq), {tag, " hold"});
    step();
    irq_in[irq] = 1'b0;
    expect_out(32'h0, {tag, " drop"});
    step();
  endtask

  initial begin : watchdog
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : driver
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_irq = '0; cmd_data = '0; irq_in = '0;
    repeat (3) step();
    rst_n = 1'b1;
    expect_out(32'h0, "R1 reset outputs low");
    checks++;
    if (cmd_ready !== 1'b1) begin
      fails++;
      $display("FAIL R11: cmd_ready=%b expected 1", cmd_ready);
    end
    step();

    // source 0: fixed, level, core 1, but distributor still off
    cmd(2'd1, 0, 32'h2);
    cmd(2'd2, 0, 32'h11);
    cmd(2'd3, 0, 32'h0);
    irq_in[0] = 1'b1;
    expect_out(32'h0, "R2 disabled");
    step();
    irq_in[0] = 1'b0;
    step();

    cmd(2'd0, 0, 32'h0);
    irq_in[0] = 1'b1;
    expect_out(line(1, 0), "R6 R10 fixed level");
    step();
    expect_out(line(1, 0), "R6 level held");
    step();
    irq_in[0] = 1'b0;
    expect_out(32'h0, "R6 level dropped");
    step();

    // mode word with junk bits: scheme 01 fixed, bit4 clear -> edge
    cmd(2'd2, 0, 32'hFFFF_FFE1);
    irq_in[0] = 1'b1;
    expect_out(line(1, 0), "R9 R4 edge pulse");
    step();
    expect_out(32'h0, "R9 pulse ends");
    step();
    irq_in[0] = 1'b0;
    step();

    // source 3: round-robin level over cores 0,1,3
    cmd(2'd1, 3, 32'hB);
    cmd(2'd2, 3, 32'h10);
    cmd(2'd3, 3, 32'h0);
    rr_level_pulse(3, 0, "R7 first");
    rr_level_pulse(3, 1, "R7 second");
    rr_level_pulse(3, 3, "R7 skip core 2");
    rr_level_pulse(3, 0, "R7 wrap");

    cmd(2'd3, 3, 32'h1);
    irq_in[3] = 1'b1;
    expect_out(32'h0, "R5 blocked");
    step();
    irq_in[3] = 1'b0;
    step();
    cmd(2'd3, 3, 32'hFFFF_FFFE);
    rr_level_pulse(3, 1, "R5 unblock R8 position kept");

    cmd(2'd1, 3, 32'h0);
    irq_in[3] = 1'b1;
    expect_out(32'h0, "R8 empty mask");
    step();
    irq_in[3] = 1'b0;
    step();
    cmd(2'd1, 3, 32'hF);
    rr_level_pulse(3, 2, "R8 position unchanged");

    // source 5: fixed level to cores 0 and 2, junk high data bits
    cmd(2'd1, 5, 32'hFFFF_FF05);
    cmd(2'd2, 5, 32'h11);
    cmd(2'd3, 5, 32'h0);
    irq_in[5] = 1'b1;
    expect_out(line(0, 5) | line(2, 5), "R3 R6 two cores");
    step();
    irq_in[5] = 1'b0;
    step();
    cmd(2'd2, 5, 32'h13);
    irq_in[5] = 1'b1;
    expect_out(line(0, 5) | line(2, 5), "R4 scheme 3 is fixed");
    step();
    irq_in[5] = 1'b0;
    step();

    // source 6: unblock command in the same cycle the input rises
    cmd(2'd1, 6, 32'h8);
    cmd(2'd2, 6, 32'h11);
    cmd_valid = 1'b1; cmd_op = 2'd3; cmd_irq = 3'd6; cmd_data = 32'h0;
    irq_in[6] = 1'b1;
    expect_out(32'h0, "R11 command not yet applied");
    step();
    cmd_valid = 1'b0;
    expect_out(line(3, 6), "R11 R5 applied next cycle");
    step();
    irq_in[6] = 1'b0;
    step();

    // source 2: round-robin edge over all cores
    cmd(2'd1, 2, 32'hF);
    cmd(2'd2, 2, 32'h0);
    cmd(2'd3, 2, 32'h0);
    irq_in[2] = 1'b1;
    expect_out(line(0, 2), "R9 R7 rotate edge first");
    step();
    expect_out(32'h0, "R9 rotate edge ends");
    step();
    irq_in[2] = 1'b0;
    step();
    irq_in[2] = 1'b1;
    expect_out(line(1, 2), "R9 R7 rotate edge next");
    step();
    irq_in[2] = 1'b0;
    step();

    step();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule